// File: doc/BRIEF.md
# Flat Panel Power Sequencer

This block turns a flat panel's power control lines on and off in a fixed order, one line per step. Each step is spaced from the one before by a programmable number of display frames. A frame-start pulse from the display timing drives the count of frames. A single request bit chooses the direction. When it is 1 the lines are raised, starting with panel supply, then the data drive, then the backlight. When it is 0 they are lowered in the reverse order.

A 3-bit delay field sets how many frame pulses separate two line transitions. A field of 0 behaves as 1. The panel-on status output moves only when a whole sequence has finished. It is set in the cycle the last line rises and cleared in the cycle the last line falls. If the request flips while a sequence is running, the frames already counted toward the next step still count. That step then moves toward the new request, and the sequence continues back from the current position.

Top module: `panel_pwr_seq`

## Requirements
- R1: While reset is asserted, and just after it is released, all control lines are 0 and panel_on_o is 0.
- R2: With pwr_req_i at 1, the lines rise one at a time in the order bit 0 (panel supply), bit 1 (data drive), bit 2 (backlight). At any moment the set of raised lines is a contiguous run that starts at bit 0.
- R3: With pwr_req_i at 0, the lines fall one at a time in the order bit 2, bit 1, bit 0, and never more than one line changes in a cycle.
- R4: A step happens on the D-th frame_start_i pulse counted since the last step or since the sequence started, where D is the value of dly_frames_i. The changed line is visible from the clock edge that samples that pulse.
- R5: A dly_frames_i of 0 is treated as 1, so every frame pulse produces a step.
- R6: panel_on_o rises in the same cycle as bit 2 rises and falls in the same cycle as bit 0 falls. While the lines are only partly raised, it keeps its value.
- R7: A change of pwr_req_i during a sequence keeps the frames already counted. The next step moves toward the new request, and panel_on_o keeps its value until the reversed sequence completes.
- R8: The control lines change only at a clock edge where frame_start_i is sampled high.
- R9: While the request is already met (all lines up with request 1, or all down with request 0), frame pulses are not counted. The count restarts from zero when the next sequence begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | One-cycle pulse at the start of each display frame |
| pwr_req_i | input | 1 | 1 requests panel power on, 0 requests off |
| dly_frames_i | input | 3 | Frames between line transitions (0 acts as 1) |
| pwr_lines_o | output | 3 | Control lines: bit 0 supply, bit 1 data drive, bit 2 backlight |
| panel_on_o | output | 1 | Panel power status, changes only at sequence end |

## Verification
The assertions check on every cycle that the lines form a contiguous run from bit 0 and change by at most one line. They also check that a change only follows a sampled frame pulse, that lines move only in the requested direction, and that the status moves only with a fully raised or fully lowered set of lines. Whether a step lands on exactly the right frame pulse cannot be seen by a property. Neither can a delay of 0 acting as 1, the carry-over of counted frames across a reversal, or the count restart after an idle period. The bench shows these with directed scenarios and with random traffic compared against a cycle model.

// File: rtl/panel_pwr_pkg.sv
package panel_pwr_pkg;
  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } seq_dir_e;
endpackage

// File: rtl/pps_dir_sel.sv
module pps_dir_sel
  import panel_pwr_pkg::*;
#(
  parameter int unsigned NUM_LINES = 3,
  parameter int unsigned LVL_W     = $clog2(NUM_LINES + 1)
) (
  input  logic [LVL_W-1:0] level_i,
  input  logic             req_i,
  output seq_dir_e         dir_o
);
  localparam logic [LVL_W-1:0] LvlFull = LVL_W'(NUM_LINES);

  always_comb begin
    if (req_i && (level_i != LvlFull))      dir_o = DIR_UP;
    else if (!req_i && (level_i != '0))     dir_o = DIR_DOWN;
    else                                    dir_o = DIR_HOLD;
  end
endmodule

// File: rtl/pps_frame_cnt.sv
module pps_frame_cnt #(
  parameter int unsigned DLY_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             frame_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             step_o
);
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] eff_dly;
  logic             last_frame;

  // zero delay behaves as a single frame
  assign eff_dly    = (dly_i == '0) ? DLY_W'(1) : dly_i;
  assign last_frame = (cnt_q >= (eff_dly - DLY_W'(1)));
  assign step_o     = active_i && frame_i && last_frame;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!active_i)     cnt_q <= '0;
    else if (step_o)        cnt_q <= '0;
    else if (frame_i)       cnt_q <= cnt_q + DLY_W'(1);
  end
endmodule

// File: rtl/pps_level.sv
module pps_level
  import panel_pwr_pkg::*;
#(
  parameter int unsigned NUM_LINES = 3,
  parameter int unsigned LVL_W     = $clog2(NUM_LINES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  seq_dir_e         dir_i,
  output logic [LVL_W-1:0] level_o,
  output logic             on_o
);
  localparam logic [LVL_W-1:0] LvlTop = LVL_W'(NUM_LINES - 1);

  logic [LVL_W-1:0] level_q;
  logic             on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0;
      on_q    <= 1'b0;
    end else if (step_i) begin
      unique case (dir_i)
        DIR_UP: begin
          level_q <= level_q + LVL_W'(1);
          if (level_q == LvlTop) on_q <= 1'b1;
        end
        DIR_DOWN: begin
          level_q <= level_q - LVL_W'(1);
          if (level_q == LVL_W'(1)) on_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign level_o = level_q;
  assign on_o    = on_q;
endmodule

// File: rtl/pps_therm.sv
module pps_therm #(
  parameter int unsigned NUM_LINES = 3,
  parameter int unsigned LVL_W     = $clog2(NUM_LINES + 1)
) (
  input  logic [LVL_W-1:0]     level_i,
  output logic [NUM_LINES-1:0] lines_o
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign lines_o[g] = (level_i > LVL_W'(g));
  end
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import panel_pwr_pkg::*;
#(
  parameter int unsigned NUM_LINES = 3,
  parameter int unsigned DLY_W     = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 frame_start_i,
  input  logic                 pwr_req_i,
  input  logic [DLY_W-1:0]     dly_frames_i,
  output logic [NUM_LINES-1:0] pwr_lines_o,
  output logic                 panel_on_o
);
  localparam int unsigned LvlW = $clog2(NUM_LINES + 1);

  logic [LvlW-1:0] level;
  seq_dir_e        dir;
  logic            step;

  pps_dir_sel #(.NUM_LINES(NUM_LINES), .LVL_W(LvlW)) i_dir_sel (
    .level_i (level),
    .req_i   (pwr_req_i),
    .dir_o   (dir)
  );

  pps_frame_cnt #(.DLY_W(DLY_W)) i_frame_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (dir != DIR_HOLD),
    .frame_i  (frame_start_i),
    .dly_i    (dly_frames_i),
    .step_o   (step)
  );

  pps_level #(.NUM_LINES(NUM_LINES), .LVL_W(LvlW)) i_level (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .dir_i   (dir),
    .level_o (level),
    .on_o    (panel_on_o)
  );

  pps_therm #(.NUM_LINES(NUM_LINES), .LVL_W(LvlW)) i_therm (
    .level_i (level),
    .lines_o (pwr_lines_o)
  );
endmodule

// File: rtl/panel_pwr_seq_chk.sv
module panel_pwr_seq_chk #(
  parameter int unsigned NUM_LINES = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 frame_start_i,
  input logic                 pwr_req_i,
  input logic [NUM_LINES-1:0] pwr_lines_o,
  input logic                 panel_on_o
);
  assert_contiguous_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pwr_lines_o + NUM_LINES'(1)) & pwr_lines_o) == '0);

  assert_one_line_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $countones(pwr_lines_o ^ $past(pwr_lines_o)) <= 1);

  assert_frame_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(pwr_lines_o));

  assert_no_rise_when_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_req_i |=> !(pwr_lines_o > $past(pwr_lines_o)));

  assert_no_fall_when_on_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_req_i |=> !(pwr_lines_o < $past(pwr_lines_o)));

  assert_on_rise_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(panel_on_o) |-> (&pwr_lines_o));

  assert_on_fall_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(panel_on_o) |-> (pwr_lines_o == '0));

  assert_on_hold_partial_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pwr_lines_o != '0) && !(&pwr_lines_o)) |-> $stable(panel_on_o));
endmodule

bind panel_pwr_seq panel_pwr_seq_chk #(.NUM_LINES(NUM_LINES)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_start_i (frame_start_i),
  .pwr_req_i     (pwr_req_i),
  .pwr_lines_o   (pwr_lines_o),
  .panel_on_o    (panel_on_o)
);

// File: tb/test_panel_pwr_seq.sv
module test_panel_pwr_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame = 1'b0;
  logic       req = 1'b0;
  logic [2:0] dly = 3'd1;
  logic [2:0] lines;
  logic       on;

  int checks = 0;
  int fails  = 0;

  int m_lvl = 0;
  int m_cnt = 0;
  bit m_on  = 1'b0;

  always #2.5 clk = ~clk;

  panel_pwr_seq i_panel_pwr_seq (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .frame_start_i (frame),
    .pwr_req_i     (req),
    .dly_frames_i  (dly),
    .pwr_lines_o   (lines),
    .panel_on_o    (on)
  );

  function automatic int eff_dly(input logic [2:0] d);
    return (d == 3'd0) ? 1 : int'(d);
  endfunction

  function automatic logic [2:0] therm(input int lvl);
    return 3'((1 << lvl) - 1);
  endfunction

  // reference cycle model built from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lvl <= 0; m_cnt <= 0; m_on <= 1'b0;
    end else begin
      automatic bit up   = req && (m_lvl < 3);
      automatic bit down = !req && (m_lvl > 0);
      if (!(up || down)) m_cnt <= 0;
      else if (frame) begin
        if (m_cnt + 1 >= eff_dly(dly)) begin
          m_cnt <= 0;
          if (up) begin
            m_lvl <= m_lvl + 1;
            if (m_lvl == 2) m_on <= 1'b1;
          end else begin
            m_lvl <= m_lvl - 1;
            if (m_lvl == 1) m_on <= 1'b0;
          end
        end else m_cnt <= m_cnt + 1;
      end
    end
  end

  task automatic check(input string tag, input logic [2:0] exp_l, input logic exp_on);
    checks++;
    if (lines !== exp_l || on !== exp_on) begin
      fails++;
      $display("FAIL %s: lines=%b on=%b expected lines=%b on=%b", tag, lines, on, exp_l, exp_on);
    end
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) frame = 1'b1;
      @(negedge clk) frame = 1'b0;
    end
  endtask

  task automatic set_req(input logic v);
    @(negedge clk) req = v;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    #1 check("R1 in reset", 3'b000, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk) check("R1 after release", 3'b000, 1'b0);

    // power-up, 2 frames per step
    dly = 3'd2;
    set_req(1'b1);
    pulse(1); check("R4 one of two frames", 3'b000, 1'b0);
    pulse(1); check("R2 supply first", 3'b001, 1'b0);
    pulse(2); check("R2 data second", 3'b011, 1'b0);
    check("R6 status held partial", 3'b011, 1'b0);
    pulse(1); check("R4 mid step", 3'b011, 1'b0);
    pulse(1); check("R6 status with last line", 3'b111, 1'b1);

    // power-down with zero delay
    dly = 3'd0;
    set_req(1'b0);
    pulse(1); check("R5 backlight off first R3", 3'b011, 1'b1);
    pulse(1); check("R3 data off", 3'b001, 1'b1);
    pulse(1); check("R6 status clears at end", 3'b000, 1'b0);

    // reversal part-way
    dly = 3'd1;
    set_req(1'b1);
    pulse(2); check("R7 partial up", 3'b011, 1'b0);
    set_req(1'b0);
    pulse(1); check("R7 reversed step", 3'b001, 1'b0);
    pulse(1); check("R7 reversed done", 3'b000, 1'b0);

    // reversal keeps counted frames
    dly = 3'd3;
    set_req(1'b1);
    pulse(2); check("R7 counting", 3'b000, 1'b0);
    pulse(1); check("R7 first up", 3'b001, 1'b0);
    pulse(2);
    set_req(1'b0);
    pulse(1); check("R7 carried count steps down", 3'b000, 1'b0);

    // idle: no counting, fresh count
    pulse(3); check("R9 idle stays off", 3'b000, 1'b0);
    set_req(1'b1);
    pulse(1);
    set_req(1'b0);
    set_req(1'b1);
    pulse(2); check("R9 count restarted", 3'b000, 1'b0);
    pulse(1); check("R9 step after full count", 3'b001, 1'b0);

    // R8: no frames, request toggling, nothing moves
    dly = 3'd1;
    for (int i = 0; i < 6; i++) begin
      set_req(i[0]);
    end
    @(negedge clk) check("R8 no frame no change", 3'b001, 1'b0);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      check("R4 random vs model", therm(m_lvl), m_on);
      frame = ($urandom_range(3) == 0);
      if ($urandom_range(40) == 0) req = ~req;
      if ($urandom_range(60) == 0) dly = 3'($urandom_range(7));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule